// File: doc/BRIEF.md
# Flood Group Index Generator

This block produces the multicast group index (MID) used to replicate a frame whose destination address was not found in the forwarding database. On each miss strobe the block reads a small configuration table. The table is addressed by the frame's packet-type code together with the bridge-type bit. Bridge type 0 serves VLAN-aware (802.1Q) forwarding IDs and bridge type 1 serves VLAN-unaware (802.1D) ones.

Each table entry holds a valid bit, a 16-bit MID base and a selector. The selector chooses what is added to the base: either the FID itself or the per-FID flood offset that arrives with the lookup. The registered result appears one cycle after the miss. It carries the MID, a drop flag and an overflow flag.

Some FIDs, such as router FIDs, are marked as handled by firmware. These skip the table, and the block reports that no hardware flood index applies. The table is loaded through a one-cycle write port.

Top module: `flood_idx_gen`

## Requirements
- R1: After reset all result outputs are 0 and every table entry is invalid, so a miss to any unwritten entry is reported with res_drop=1.
- R2: In a cycle with lk_miss=0 the next cycle shows res_vld=0, res_drop=0, res_ovf=0, res_fw=0 and res_mid=0.
- R3: A miss presented in cycle N produces res_vld=1 with its result in cycle N+1; back-to-back misses give back-to-back results.
- R4: The table entry used is selected by the index {bridge bit, 4-bit packet type}; the entries for bridge 0 and bridge 1 with the same packet type are independent.
- R5: Selector value 0 adds lk_fid to the base; selector value 1 adds lk_ofs to the base.
- R6: For a valid entry with no overflow, res_mid equals base plus addend, including the boundary sum 16'hFFFF, with res_drop=0.
- R7: A miss that hits an entry whose valid bit is 0 gives res_drop=1, res_ovf=0 and res_mid=0.
- R8: If base plus addend exceeds 16'hFFFF, the result has res_ovf=1, res_drop=1 and res_mid=0.
- R9: A miss with lk_fw=1 bypasses the table: res_fw=1, res_drop=0, res_ovf=0, res_mid=0, whatever the entry holds.
- R10: A table write in the same cycle as a miss to the same entry does not affect that miss; the new contents apply from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_pkt | input | 4 | Packet-type part of the write index |
| cfg_bridge | input | 1 | Bridge-type part of the write index |
| cfg_sel | input | 1 | Addend selector to store (0 FID, 1 offset) |
| cfg_base | input | 16 | MID base to store |
| cfg_vld | input | 1 | Valid bit to store |
| lk_miss | input | 1 | Forwarding lookup missed this cycle |
| lk_pkt | input | 4 | Packet-type code of the frame |
| lk_bridge | input | 1 | Bridge type of the frame's FID |
| lk_fid | input | 16 | Forwarding ID |
| lk_ofs | input | 16 | Per-FID flood offset |
| lk_fw | input | 1 | FID flooding is handled by firmware |
| res_vld | output | 1 | Result present |
| res_mid | output | 16 | Computed multicast group index |
| res_drop | output | 1 | Frame is dropped (invalid entry or overflow) |
| res_ovf | output | 1 | Base plus addend overflowed 16 bits |
| res_fw | output | 1 | No hardware index; firmware floods |

## Verification
Every result is due exactly one clock edge after the miss that caused it. Table writes become visible to misses presented from the cycle after the write. The bench drives each input on a falling edge and samples on the following falling edge. One rising edge therefore separates stimulus from observation, and the miss is withdrawn before the next edge. The same-cycle write case drives the write and the miss together on one falling edge. The bench then checks the old contents at the next sample point and the new contents one cycle later.

// File: rtl/flood_idx_pkg.sv
package flood_idx_pkg;

    parameter int FG_MID_W = 16;
    parameter int FG_PKT_W = 4;
    localparam int FG_IDX_W = FG_PKT_W + 1;
    localparam int FG_DEPTH = 1 << FG_IDX_W;

    typedef enum logic {
        SEL_FID = 1'b0,
        SEL_OFS = 1'b1
    } fg_sel_e;

    typedef struct packed {
        logic                vld;
        fg_sel_e             sel;
        logic [FG_MID_W-1:0] base;
    } fg_entry_t;

    typedef struct packed {
        logic                vld;
        logic [FG_MID_W-1:0] mid;
        logic                drop;
        logic                ovf;
        logic                fw;
    } fg_result_t;

    function automatic logic [FG_IDX_W-1:0] fg_index(input logic bridge,
                                                     input logic [FG_PKT_W-1:0] pkt);
        return {bridge, pkt};
    endfunction

endpackage

// File: rtl/flood_cfg_table.sv
module flood_cfg_table
    import flood_idx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [FG_IDX_W-1:0] wr_idx,
    input  fg_entry_t           wr_ent,
    input  logic [FG_IDX_W-1:0] rd_idx,
    output fg_entry_t           rd_ent
);

    fg_entry_t ent_q [FG_DEPTH];

    for (genvar i = 0; i < FG_DEPTH; i++) begin : g_ent
        localparam logic [FG_IDX_W-1:0] KEY = FG_IDX_W'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (wr_en && wr_idx == KEY) begin
                ent_q[i] <= wr_ent;
            end
        end
    end

    assign rd_ent = ent_q[rd_idx];

endmodule

// File: rtl/flood_mid_calc.sv
module flood_mid_calc
    import flood_idx_pkg::*;
(
    input  fg_entry_t           ent,
    input  logic [FG_MID_W-1:0] fid,
    input  logic [FG_MID_W-1:0] ofs,
    output logic [FG_MID_W-1:0] sum,
    output logic                carry
);

    logic [FG_MID_W-1:0] addend;
    logic [FG_MID_W:0]   wide;

    always_comb begin
        unique case (ent.sel)
            SEL_FID: addend = fid;
            SEL_OFS: addend = ofs;
            default: addend = fid;
        endcase
        wide  = {1'b0, ent.base} + {1'b0, addend};
        sum   = wide[FG_MID_W-1:0];
        carry = wide[FG_MID_W];
    end

endmodule

// File: rtl/flood_idx_gen.sv
module flood_idx_gen
    import flood_idx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [FG_PKT_W-1:0] cfg_pkt,
    input  logic                cfg_bridge,
    input  logic                cfg_sel,
    input  logic [FG_MID_W-1:0] cfg_base,
    input  logic                cfg_vld,
    input  logic                lk_miss,
    input  logic [FG_PKT_W-1:0] lk_pkt,
    input  logic                lk_bridge,
    input  logic [FG_MID_W-1:0] lk_fid,
    input  logic [FG_MID_W-1:0] lk_ofs,
    input  logic                lk_fw,
    output logic                res_vld,
    output logic [FG_MID_W-1:0] res_mid,
    output logic                res_drop,
    output logic                res_ovf,
    output logic                res_fw
);

    fg_entry_t           wr_ent;
    fg_entry_t           rd_ent;
    logic [FG_MID_W-1:0] sum;
    logic                carry;
    fg_result_t          nxt;
    fg_result_t          res_q;

    assign wr_ent = '{vld: cfg_vld, sel: fg_sel_e'(cfg_sel), base: cfg_base};

    flood_cfg_table u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_idx (fg_index(cfg_bridge, cfg_pkt)),
        .wr_ent (wr_ent),
        .rd_idx (fg_index(lk_bridge, lk_pkt)),
        .rd_ent (rd_ent)
    );

    flood_mid_calc u_calc (
        .ent   (rd_ent),
        .fid   (lk_fid),
        .ofs   (lk_ofs),
        .sum   (sum),
        .carry (carry)
    );

    always_comb begin
        nxt = '0;
        if (lk_miss) begin
            nxt.vld = 1'b1;
            if (lk_fw) begin
                nxt.fw = 1'b1;
            end else if (!rd_ent.vld) begin
                nxt.drop = 1'b1;
            end else if (carry) begin
                nxt.ovf  = 1'b1;
                nxt.drop = 1'b1;
            end else begin
                nxt.mid = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= nxt;
        end
    end

    assign res_vld  = res_q.vld;
    assign res_mid  = res_q.mid;
    assign res_drop = res_q.drop;
    assign res_ovf  = res_q.ovf;
    assign res_fw   = res_q.fw;

endmodule

// File: rtl/flood_idx_chk.sv
module flood_idx_chk
    import flood_idx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                lk_miss,
    input logic                lk_fw,
    input logic                res_vld,
    input logic [FG_MID_W-1:0] res_mid,
    input logic                res_drop,
    input logic                res_ovf,
    input logic                res_fw
);

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        lk_miss |=> res_vld);

    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !lk_miss |=> (!res_vld && !res_drop && !res_ovf && !res_fw && res_mid == '0));

    a_r9_fw_bypass: assert property (@(posedge clk) disable iff (rst)
        (lk_miss && lk_fw) |=> (res_fw && !res_drop && !res_ovf && res_mid == '0));

    a_r8_ovf_drops: assert property (@(posedge clk) disable iff (rst)
        res_ovf |-> (res_drop && !res_fw && res_mid == '0));

    a_r7_drop_zero: assert property (@(posedge clk) disable iff (rst)
        res_drop |-> (res_vld && res_mid == '0));

endmodule

bind flood_idx_gen flood_idx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_miss  (lk_miss),
    .lk_fw    (lk_fw),
    .res_vld  (res_vld),
    .res_mid  (res_mid),
    .res_drop (res_drop),
    .res_ovf  (res_ovf),
    .res_fw   (res_fw)
);

// File: tb/sim_flood_idx_gen.sv
module sim_flood_idx_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_bridge, cfg_sel, cfg_vld;
    logic [3:0]  cfg_pkt;
    logic [15:0] cfg_base;
    logic        lk_miss, lk_bridge, lk_fw;
    logic [3:0]  lk_pkt;
    logic [15:0] lk_fid, lk_ofs;
    logic        res_vld, res_drop, res_ovf, res_fw;
    logic [15:0] res_mid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flood_idx_gen u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_pkt(cfg_pkt), .cfg_bridge(cfg_bridge),
        .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_vld(cfg_vld),
        .lk_miss(lk_miss), .lk_pkt(lk_pkt), .lk_bridge(lk_bridge),
        .lk_fid(lk_fid), .lk_ofs(lk_ofs), .lk_fw(lk_fw),
        .res_vld(res_vld), .res_mid(res_mid), .res_drop(res_drop),
        .res_ovf(res_ovf), .res_fw(res_fw)
    );

    task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got {vld,drop,ovf,fw,mid}=%h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [19:0] pack(input logic v, input logic d, input logic o,
                                         input logic f, input logic [15:0] m);
        return {v, d, o, f, m};
    endfunction

    function automatic logic [19:0] outs();
        return {res_vld, res_drop, res_ovf, res_fw, res_mid};
    endfunction

    task automatic wr(input logic br, input logic [3:0] pkt, input logic sel,
                      input logic [15:0] base, input logic vld);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bridge = br; cfg_pkt = pkt;
        cfg_sel = sel; cfg_base = base; cfg_vld = vld;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_miss(input logic br, input logic [3:0] pkt, input logic [15:0] fid,
                              input logic [15:0] ofs, input logic fw);
        lk_miss = 1'b1; lk_bridge = br; lk_pkt = pkt;
        lk_fid = fid; lk_ofs = ofs; lk_fw = fw;
    endtask

    task automatic miss(input string req, input logic br, input logic [3:0] pkt,
                        input logic [15:0] fid, input logic [15:0] ofs, input logic fw,
                        input logic [19:0] exp);
        @(negedge clk);
        drive_miss(br, pkt, fid, ofs, fw);
        @(negedge clk);
        lk_miss = 1'b0;
        chk(req, outs(), exp);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", outs(), '0);
        miss("R1 unwritten entry drops", 1'b0, 4'd3, 16'h0010, 16'h0001, 1'b0,
             pack(1, 1, 0, 0, 16'h0));
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        chk("R2 idle outputs", outs(), '0);
    endtask

    task automatic t_select();
        wr(1'b0, 4'd2, 1'b0, 16'h0100, 1'b1);
        wr(1'b1, 4'd2, 1'b1, 16'h0200, 1'b1);
        miss("R5 fid addend", 1'b0, 4'd2, 16'h0020, 16'h0007, 1'b0, pack(1, 0, 0, 0, 16'h0120));
        miss("R4 bridge1 entry offset addend", 1'b1, 4'd2, 16'h0020, 16'h0007, 1'b0,
             pack(1, 0, 0, 0, 16'h0207));
        miss("R4 other pkt type still empty", 1'b0, 4'd5, 16'h0020, 16'h0007, 1'b0,
             pack(1, 1, 0, 0, 16'h0));
    endtask

    task automatic t_bounds();
        wr(1'b0, 4'd15, 1'b1, 16'hFFF0, 1'b1);
        miss("R6 sum at FFFF", 1'b0, 4'd15, 16'h1234, 16'h000F, 1'b0, pack(1, 0, 0, 0, 16'hFFFF));
        miss("R8 overflow", 1'b0, 4'd15, 16'h0000, 16'h0010, 1'b0, pack(1, 1, 1, 0, 16'h0));
        wr(1'b1, 4'd15, 1'b0, 16'h8000, 1'b1);
        miss("R8 overflow fid path", 1'b1, 4'd15, 16'h8000, 16'h0000, 1'b0, pack(1, 1, 1, 0, 16'h0));
    endtask

    task automatic t_invalid();
        wr(1'b0, 4'd2, 1'b0, 16'h0100, 1'b0);
        miss("R7 cleared entry drops", 1'b0, 4'd2, 16'h0020, 16'h0007, 1'b0, pack(1, 1, 0, 0, 16'h0));
    endtask

    task automatic t_fw();
        miss("R9 fw with valid entry", 1'b1, 4'd2, 16'h0020, 16'h0007, 1'b1, pack(1, 0, 0, 1, 16'h0));
        miss("R9 fw with invalid entry", 1'b0, 4'd2, 16'h0020, 16'h0007, 1'b1, pack(1, 0, 0, 1, 16'h0));
        miss("R9 fw with overflowing entry", 1'b0, 4'd15, 16'h0000, 16'h0010, 1'b1,
             pack(1, 0, 0, 1, 16'h0));
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_bridge = 1'b0; cfg_pkt = 4'd9;
        cfg_sel = 1'b1; cfg_base = 16'h0400; cfg_vld = 1'b1;
        drive_miss(1'b0, 4'd9, 16'h0001, 16'h0003, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R10 miss sees old entry", outs(), pack(1, 1, 0, 0, 16'h0));
        @(negedge clk);
        lk_miss = 1'b0;
        chk("R10 next miss sees new entry", outs(), pack(1, 0, 0, 0, 16'h0403));
    endtask

    task automatic t_stream();
        @(negedge clk);
        drive_miss(1'b1, 4'd2, 16'h0000, 16'h0001, 1'b0);
        @(negedge clk);
        chk("R3 first of stream", outs(), pack(1, 0, 0, 0, 16'h0201));
        drive_miss(1'b1, 4'd2, 16'h0000, 16'h0002, 1'b0);
        @(negedge clk);
        lk_miss = 1'b0;
        chk("R3 second of stream", outs(), pack(1, 0, 0, 0, 16'h0202));
        @(negedge clk);
        chk("R3 result ends after one cycle", outs(), '0);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_bridge = 1'b0; cfg_sel = 1'b0; cfg_vld = 1'b0;
        cfg_pkt = '0; cfg_base = '0;
        lk_miss = 1'b0; lk_bridge = 1'b0; lk_fw = 1'b0; lk_pkt = '0; lk_fid = '0; lk_ofs = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_select();
        t_bounds();
        t_invalid();
        t_fw();
        t_same_cycle();
        t_stream();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule